// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of an eight-input interrupt controller. It keeps three pieces of state:

- a register of pending requests;
- a register of requests currently in service;
- a rotating priority base.

Each input line is sampled on every clock. A line set to edge mode latches a pending request on a rising level. A line set to level mode makes its pending bit copy the line. Priority is counted outward from the stored base: the line equal to the base is the most urgent, then base+1, and so on, wrapping around. The interrupt output is raised when an unmasked pending request strictly outranks the most urgent line already in service.

The surrounding controller drives the block through strobes:

- an acknowledge strobe, which moves the winning request into service;
- a command strobe with a 3-bit code and a 3-bit line field, which performs end-of-interrupt, rotation and base-setting operations.

The mask, the per-line trigger mode, automatic end-of-interrupt, rotation on automatic end-of-interrupt and the special nested mode of a master instance arrive as steady inputs. The request output and the winning line number are derived combinationally from the registered state, so no update strobe is needed.

Top module: `prio_irq_resolver`

## Requirements
- R1: A line in edge mode (level_i bit 0) sets its pending bit only when its level is sampled 1 after being sampled 0. While the line stays high after the bit is cleared, it does not set the bit again.
- R2: A line in level mode (level_i bit 1) has its pending bit equal to the line level sampled at the previous clock edge, and an acknowledge does not clear it.
- R3: The rank of line L is (L - base) mod 8, and rank 0 is the most urgent. int_vec_o names the unmasked pending line with the lowest rank.
- R4: int_req_o is 1 only when the best unmasked pending rank is strictly lower than the best in-service rank. A mask_i bit of 1 removes that line from the request search, and an equal rank gives no request.
- R5: When sfn_master_i is 1, in-service bit 2 is excluded from the in-service rank, so a new request on line 2 can be issued while line 2 is in service.
- R6: ack_i with int_req_o high sets the in-service bit of int_vec_o. It clears that line's pending bit only in edge mode. ack_i with int_req_o low changes nothing.
- R7: Command code 0 clears the in-service bit with the lowest rank. Code 2 clears the in-service bit named by cmd_line_i. Neither changes the base.
- R8: Command code 1 acts as code 0 and also sets the base to the cleared line + 1. Code 3 acts as code 2 and also sets the base to cmd_line_i + 1. Both wrap modulo 8.
- R9: Command code 4 sets the base to (cmd_line_i + 1) mod 8 and leaves the in-service register unchanged. Codes 5 to 7 do nothing.
- R10: With auto_eoi_i at 1, an acknowledge leaves the in-service bit clear. If rot_aeoi_i is also 1, the base becomes the acknowledged line + 1.
- R11: If ack_i is honoured in a cycle, a command strobe in the same cycle is discarded.
- R12: A synchronous reset clears the pending, in-service and last-level registers and the base to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines_i | input | 8 | Interrupt request lines |
| mask_i | input | 8 | Per-line mask, 1 = masked |
| level_i | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| sfn_master_i | input | 1 | Special nested mode on a master instance |
| ack_i | input | 1 | Acknowledge strobe |
| cmd_stb_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (0..4 defined) |
| cmd_line_i | input | 3 | Line or value field of the command |
| int_req_o | output | 1 | Interrupt request to the processor |
| int_vec_o | output | 3 | Line number of the winning request |
| irr_o | output | 8 | Pending request register |
| isr_o | output | 8 | In-service register |
| base_o | output | 3 | Current priority base |

## Verification
A wrong rank computation or a stale base shows at once as a different int_vec_o, in the first cycle after the state changes. A wrong in-service bit shows as int_req_o staying low when a new request should nest, or rising when it should be held off. A pending bit that is cleared when it should not be, or set again by mistake, shows in irr_o one clock after the acknowledge or the line change. The scenarios are built so that every such fault changes a port within one or two cycles of the stimulus that causes it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [2:0] {
        CMD_EOI_TOP     = 3'd0,
        CMD_EOI_TOP_ROT = 3'd1,
        CMD_EOI_LINE    = 3'd2,
        CMD_EOI_LINE_ROT= 3'd3,
        CMD_SET_BASE    = 3'd4
    } pir_cmd_e;

endpackage

// File: rtl/pir_line_sampler.sv
module pir_line_sampler #(
    parameter int N = 8
) (
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] irr_i,
    input  logic [N-1:0] last_i,
    output logic [N-1:0] irr_o,
    output logic [N-1:0] last_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        // level lines copy the pin; edge lines accumulate rising levels
        assign irr_o[g]  = level_i[g] ? lines_i[g]
                                      : (irr_i[g] | (lines_i[g] & ~last_i[g]));
        assign last_o[g] = lines_i[g];
    end
endmodule

// File: rtl/pir_prio_scan.sv
module pir_prio_scan #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  bits_i,
    input  logic [IW-1:0] base_i,
    output logic [IW:0]   rank_o
);
    localparam logic [IW:0] NONE = (IW+1)'(N);

    always_comb begin
        logic [IW-1:0] idx;
        rank_o = NONE;
        for (int k = N - 1; k >= 0; k--) begin
            idx = base_i + IW'(k);
            if (bits_i[idx]) rank_o = (IW+1)'(k);
        end
    end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int NUM_LINES    = 8,
    parameter int CASCADE_LINE = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_LINES-1:0]         irq_lines_i,
    input  logic [NUM_LINES-1:0]         mask_i,
    input  logic [NUM_LINES-1:0]         level_i,
    input  logic                         auto_eoi_i,
    input  logic                         rot_aeoi_i,
    input  logic                         sfn_master_i,
    input  logic                         ack_i,
    input  logic                         cmd_stb_i,
    input  logic [2:0]                   cmd_i,
    input  logic [$clog2(NUM_LINES)-1:0] cmd_line_i,
    output logic                         int_req_o,
    output logic [$clog2(NUM_LINES)-1:0] int_vec_o,
    output logic [NUM_LINES-1:0]         irr_o,
    output logic [NUM_LINES-1:0]         isr_o,
    output logic [$clog2(NUM_LINES)-1:0] base_o
);
    localparam int          IW   = $clog2(NUM_LINES);
    localparam logic [IW:0] NONE = (IW+1)'(NUM_LINES);

    typedef struct packed {
        logic [NUM_LINES-1:0] irr;
        logic [NUM_LINES-1:0] isr;
        logic [NUM_LINES-1:0] last;
        logic [IW-1:0]        base;
    } pir_state_t;

    pir_state_t st_q, st_d;

    logic [NUM_LINES-1:0] irr_smp_d, last_smp_d;
    logic [NUM_LINES-1:0] req_bits_d, svc_bits_d;
    logic [IW:0]          req_rank_d, svc_rank_d, top_rank_d;
    logic [IW-1:0]        req_line_d, top_line_d;
    logic                 take_ack_d;

    pir_line_sampler #(.N(NUM_LINES)) u_sampler (
        .lines_i (irq_lines_i),
        .level_i (level_i),
        .irr_i   (st_q.irr),
        .last_i  (st_q.last),
        .irr_o   (irr_smp_d),
        .last_o  (last_smp_d)
    );

    always_comb begin
        req_bits_d = st_q.irr & ~mask_i;
        svc_bits_d = st_q.isr;
        if (sfn_master_i) svc_bits_d[CASCADE_LINE] = 1'b0;
    end

    pir_prio_scan #(.N(NUM_LINES), .IW(IW)) u_req_scan (
        .bits_i (req_bits_d), .base_i (st_q.base), .rank_o (req_rank_d)
    );
    pir_prio_scan #(.N(NUM_LINES), .IW(IW)) u_svc_scan (
        .bits_i (svc_bits_d), .base_i (st_q.base), .rank_o (svc_rank_d)
    );
    pir_prio_scan #(.N(NUM_LINES), .IW(IW)) u_eoi_scan (
        .bits_i (st_q.isr), .base_i (st_q.base), .rank_o (top_rank_d)
    );

    assign req_line_d = req_rank_d[IW-1:0] + st_q.base;
    assign top_line_d = top_rank_d[IW-1:0] + st_q.base;
    assign int_req_o  = (req_rank_d < svc_rank_d);
    assign int_vec_o  = req_line_d;
    assign take_ack_d = ack_i & int_req_o;

    always_comb begin
        st_d      = st_q;
        st_d.irr  = irr_smp_d;
        st_d.last = last_smp_d;
        if (take_ack_d) begin
            st_d.isr[req_line_d] = 1'b1;
            if (!level_i[req_line_d]) st_d.irr[req_line_d] = 1'b0;
            if (auto_eoi_i) begin
                st_d.isr[req_line_d] = 1'b0;
                if (rot_aeoi_i) st_d.base = req_line_d + IW'(1);
            end
        end else if (cmd_stb_i) begin
            case (cmd_i)
                CMD_EOI_TOP, CMD_EOI_TOP_ROT: begin
                    if (top_rank_d != NONE) begin
                        st_d.isr[top_line_d] = 1'b0;
                        if (cmd_i == CMD_EOI_TOP_ROT) st_d.base = top_line_d + IW'(1);
                    end
                end
                CMD_EOI_LINE: st_d.isr[cmd_line_i] = 1'b0;
                CMD_EOI_LINE_ROT: begin
                    st_d.isr[cmd_line_i] = 1'b0;
                    st_d.base            = cmd_line_i + IW'(1);
                end
                CMD_SET_BASE: st_d.base = cmd_line_i + IW'(1);
                default: ;
            endcase
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign irr_o  = st_q.irr;
    assign isr_o  = st_q.isr;
    assign base_o = st_q.base;
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  irq_lines_i,
    input logic [N-1:0]  mask_i,
    input logic [N-1:0]  level_i,
    input logic          auto_eoi_i,
    input logic          ack_i,
    input logic          cmd_stb_i,
    input logic [2:0]    cmd_i,
    input logic [IW-1:0] cmd_line_i,
    input logic          int_req_o,
    input logic [IW-1:0] int_vec_o,
    input logic [N-1:0]  irr_o,
    input logic [N-1:0]  isr_o,
    input logic [IW-1:0] base_o
);
    // R12
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (irr_o == '0 && isr_o == '0 && base_o == '0));

    // R4
    req_is_pending_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        int_req_o |-> (irr_o[int_vec_o] && !mask_i[int_vec_o]));

    // R2
    level_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((irr_o ^ $past(irq_lines_i)) & $past(level_i)) == '0));

    // R6
    ack_enters_service_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && int_req_o && !auto_eoi_i) |=> isr_o[$past(int_vec_o)]);

    // R10
    auto_eoi_leaves_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && int_req_o && auto_eoi_i) |=> !isr_o[$past(int_vec_o)]);

    // R9
    set_base_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb_i && !(ack_i && int_req_o) && cmd_i == 3'd4)
        |=> (base_o == $past(cmd_line_i) + IW'(1) && isr_o == $past(isr_o)));
endmodule

bind prio_irq_resolver pir_checker #(.N(NUM_LINES), .IW($clog2(NUM_LINES))) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_lines_i (irq_lines_i),
    .mask_i      (mask_i),
    .level_i     (level_i),
    .auto_eoi_i  (auto_eoi_i),
    .ack_i       (ack_i),
    .cmd_stb_i   (cmd_stb_i),
    .cmd_i       (cmd_i),
    .cmd_line_i  (cmd_line_i),
    .int_req_o   (int_req_o),
    .int_vec_o   (int_vec_o),
    .irr_o       (irr_o),
    .isr_o       (isr_o),
    .base_o      (base_o)
);

// File: tb/prio_irq_resolver_tb.sv
module prio_irq_resolver_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] lines, mask, level;
    logic       aeoi, rot_aeoi, sfn, ack, cmd_stb;
    logic [2:0] cmd, cmd_line;
    logic       int_req;
    logic [2:0] int_vec, base;
    logic [7:0] irr, isr;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prio_irq_resolver u_dut (
        .clk (clk), .rst (rst), .irq_lines_i (lines), .mask_i (mask),
        .level_i (level), .auto_eoi_i (aeoi), .rot_aeoi_i (rot_aeoi),
        .sfn_master_i (sfn), .ack_i (ack), .cmd_stb_i (cmd_stb),
        .cmd_i (cmd), .cmd_line_i (cmd_line), .int_req_o (int_req),
        .int_vec_o (int_vec), .irr_o (irr), .isr_o (isr), .base_o (base)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        lines = 0; mask = 0; level = 0; aeoi = 0; rot_aeoi = 0; sfn = 0;
        ack = 0; cmd_stb = 0; cmd = 0; cmd_line = 0;
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic do_ack();
        ack = 1; step(); ack = 0;
    endtask

    task automatic do_cmd(logic [2:0] c, logic [2:0] l);
        cmd = c; cmd_line = l; cmd_stb = 1; step(); cmd_stb = 0;
    endtask

    task automatic t_reset();
        lines = 8'hFF; rst = 1; step(); step(); rst = 0; lines = 0;
        chk("R12 irr", irr, 8'h00);
        chk("R12 isr", isr, 8'h00);
        chk("R12 base", base, 3'd0);
        chk("R12 int_req", int_req, 1'b0);
        do_reset();
        do_ack();
        chk("R6 spurious ack isr", isr, 8'h00);
    endtask

    task automatic t_edge();
        do_reset();
        lines = 8'h10; step();
        chk("R1 latch", irr, 8'h10);
        chk("R3 vec", int_vec, 3'd4);
        do_ack();
        chk("R6 edge cleared", irr, 8'h00);
        chk("R6 isr set", isr, 8'h10);
        step(); step();
        chk("R1 held high no relatch", irr, 8'h00);
        lines = 0; step(); lines = 8'h10; step();
        chk("R1 new edge", irr, 8'h10);
    endtask

    task automatic t_level();
        do_reset();
        level = 8'h40; lines = 8'h40; step();
        chk("R2 follow high", irr, 8'h40);
        do_ack();
        chk("R2 kept after ack", irr, 8'h40);
        chk("R6 isr", isr, 8'h40);
        chk("R4 equal rank no req", int_req, 1'b0);
        lines = 0; step();
        chk("R2 follow low", irr, 8'h00);
    endtask

    task automatic t_mask();
        do_reset();
        mask = 8'h02; lines = 8'h02; step();
        chk("R4 masked pending", irr, 8'h02);
        chk("R4 masked no req", int_req, 1'b0);
        mask = 0; step();
        chk("R4 unmasked req", {int_req, int_vec}, {1'b1, 3'd1});
    endtask

    task automatic t_prio();
        do_reset();
        lines = 8'h28; step();
        chk("R3 lowest rank wins", int_vec, 3'd3);
        do_ack();
        chk("R4 lower held off", int_req, 1'b0);
        lines = 8'h2A; step();
        chk("R4 nesting", {int_req, int_vec}, {1'b1, 3'd1});
    endtask

    task automatic t_eoi();
        do_reset();
        lines = 8'h20; step(); do_ack();
        lines = 8'h24; step();
        chk("R4 nest line2", {int_req, int_vec}, {1'b1, 3'd2});
        do_ack();
        chk("R6 two in service", isr, 8'h24);
        do_cmd(3'd0, 3'd0);
        chk("R7 nonspecific", isr, 8'h20);
        do_cmd(3'd2, 3'd5);
        chk("R7 specific", isr, 8'h00);
        chk("R7 base unchanged", base, 3'd0);
    endtask

    task automatic t_rotate();
        do_reset();
        lines = 8'h20; step(); do_ack();
        do_cmd(3'd1, 3'd0);
        chk("R8 rot eoi isr", isr, 8'h00);
        chk("R8 rot eoi base", base, 3'd6);
        lines = 8'hA1; step();
        chk("R3 rotated order", int_vec, 3'd7);
        do_cmd(3'd4, 3'd7);
        chk("R9 set base wraps", base, 3'd0);
        chk("R9 vec after set", int_vec, 3'd0);
        do_ack();
        chk("R6 ack line0", isr, 8'h01);
        do_cmd(3'd5, 3'd2);
        chk("R9 code5 noop", {isr, 5'd0, base}, {8'h01, 5'd0, 3'd0});
        do_cmd(3'd3, 3'd0);
        chk("R8 specific rotate", {isr, 5'd0, base}, {8'h00, 5'd0, 3'd1});
        chk("R8 vec after rotate", {int_req, int_vec}, {1'b1, 3'd7});
    endtask

    task automatic t_aeoi();
        do_reset();
        aeoi = 1; rot_aeoi = 1;
        lines = 8'h08; step(); do_ack();
        chk("R10 isr clear", isr, 8'h00);
        chk("R10 base", base, 3'd4);
        chk("R10 irr", irr, 8'h00);
    endtask

    task automatic t_sfn();
        do_reset();
        lines = 8'h04; step(); do_ack();
        lines = 0; step(); lines = 8'h04; step();
        chk("R5 off equal rank", int_req, 1'b0);
        sfn = 1; step();
        chk("R5 on cascade reissued", {int_req, int_vec}, {1'b1, 3'd2});
    endtask

    task automatic t_same_cycle();
        do_reset();
        lines = 8'h10; step();
        ack = 1; cmd = 3'd4; cmd_line = 3'd3; cmd_stb = 1; step();
        ack = 0; cmd_stb = 0;
        chk("R11 base kept", base, 3'd0);
        chk("R11 ack taken", isr, 8'h10);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_level();
        t_mask();
        t_prio();
        t_eoi();
        t_rotate();
        t_aeoi();
        t_sfn();
        t_same_cycle();
        finish_run();
    end
endmodule